// File: doc/BRIEF.md
# Timer Compare Output PWM Unit

An 8-bit timer/counter with two compare channels, A and B, each driving one waveform output. A 3-bit waveform mode selects how the counter runs and where its TOP lies. Each channel's 2-bit output-action field then picks what its output does when the count matches that channel's compare value, or when the count reaches TOP. Three families of waveform mode exist: plain counting and clear-on-compare (non-PWM), single-slope fast PWM, and dual-slope phase-correct PWM.

The counter advances only on cycles where the tick input is high, so an outside prescaler can pace it. In both PWM families the compare values are double-buffered, which keeps pulses free of glitches when software changes a value. For each channel the unit also reports whether the waveform takes over the pin, and whether the output driver is turned on. The driver is on only when the pin's direction bit asks for an output.

Top module: `tmr_pwm_unit`

## Requirements
- R1: Action field 00 leaves a channel disconnected: its override and driver-enable outputs are 0. Any other value sets override to 1, except in the cases of R6.
- R2: Driver enable is 1 only when override is 1 and the channel's direction bit is 1. With direction 0 it stays 0 while override is still reported.
- R3: Non-PWM families: on a compare match, 01 toggles the output, 10 clears it and 11 sets it. Normal mode counts 0..255 and wraps to 0. Clear-on-compare mode goes to 0 on the count after the count equals the channel-A compare value.
- R4: Fast PWM: the counter wraps from TOP to 0. Action 10 sets the output at TOP and clears it on a match. Action 11 clears it at TOP and sets it on a match.
- R5: Phase-correct PWM: the counter runs 0,1..TOP, TOP-1..1,0,1.. A count of 0 or TOP counts as up-counting. Action 10 clears the output on an up-counting match and sets it on a down-counting match. Action 11 does the reverse.
- R6: Action 01 in a PWM family: channel B is disconnected (override 0). Channel A is disconnected when waveform-mode bit 2 is 0, and toggles on every match when that bit is 1.
- R7: In a PWM family, if a channel's compare value equals TOP and its action is 10 or 11, the match is ignored and only the TOP action applies. In fast PWM that is the action of R4. In phase-correct PWM it is the down-counting match level, applied when the count is TOP.
- R8: In fast PWM a new compare value takes effect on the tick that wraps the count from TOP to 0. In phase-correct PWM it takes effect on the up-counting tick at TOP. In non-PWM families it takes effect on the next clock.
- R9: Counter and outputs change only on clocks with tick high. An output change caused by count value k appears on the same edge at which the counter leaves k.
- R10: Reset clears the counter, sets up-counting, clears both compare buffers and drives both waveform outputs low.
- R11: Waveform mode encoding: 0 normal, 1 phase-correct with TOP 255, 2 clear-on-compare with TOP equal to compare A, 3 fast with TOP 255, 5 phase-correct with TOP equal to compare A, 7 fast with TOP equal to compare A. Codes 4 and 6 behave as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable |
| wgm_i | input | 3 | Waveform mode |
| com_a_i | input | 2 | Channel A output action |
| com_b_i | input | 2 | Channel B output action |
| ocr_a_i | input | 8 | Channel A compare value |
| ocr_b_i | input | 8 | Channel B compare value |
| dir_a_i | input | 1 | Channel A pin direction (1 = output) |
| dir_b_i | input | 1 | Channel B pin direction (1 = output) |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| ovr_a_o | output | 1 | Channel A waveform overrides the pin |
| ovr_b_o | output | 1 | Channel B waveform overrides the pin |
| oe_a_o | output | 1 | Channel A output driver enabled |
| oe_b_o | output | 1 | Channel B output driver enabled |

## Verification
The sweep covers all eight waveform codes against every output action on both channels. It uses compare pairs that place a value below TOP, equal to TOP, at 0, and above a small TOP. These pairs separate the ordinary match path, the equal-to-TOP override, bottom matches and matches that never occur. Runs with a sparse tick show that state holds between ticks. Runs that change the compare values mid-period show that each family loads the new value at its own point, TOP, BOTTOM or at once. Direct cases cover direction gating, disconnect, and an asynchronous reset while an output is high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    FAM_NORMAL = 2'd0,
    FAM_CTC    = 2'd1,
    FAM_FAST   = 2'd2,
    FAM_PHASE  = 2'd3
  } fam_e;

  typedef struct packed {
    fam_e fam;
    logic top_ocr;  // TOP taken from channel-A compare
  } wmode_t;

  function automatic wmode_t decode_wgm(input logic [2:0] w);
    wmode_t m;
    m.fam     = FAM_NORMAL;
    m.top_ocr = 1'b0;
    case (w)
      3'd1: m.fam = FAM_PHASE;
      3'd2: begin m.fam = FAM_CTC;   m.top_ocr = 1'b1; end
      3'd3: m.fam = FAM_FAST;
      3'd5: begin m.fam = FAM_PHASE; m.top_ocr = 1'b1; end
      3'd7: begin m.fam = FAM_FAST;  m.top_ocr = 1'b1; end
      default: ;
    endcase
    return m;
  endfunction

  function automatic logic is_pwm(input fam_e f);
    return (f == FAM_FAST) || (f == FAM_PHASE);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  fam_e             fam_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d, at_top;

  always_comb begin
    at_top = cnt_q >= top_i;
    cnt_d  = cnt_q + ONE;
    up_d   = 1'b1;
    unique case (fam_i)
      FAM_CTC:  if (cnt_q == top_i) cnt_d = '0;
      FAM_FAST: if (at_top) cnt_d = '0;
      FAM_PHASE: begin
        if (up_q) begin
          if (at_top) cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
        end else begin
          cnt_d = (cnt_q == '0) ? ONE : cnt_q - ONE;
        end
        // arriving at bottom always resumes up-counting
        up_d = (cnt_d == '0) ? 1'b1 : ((up_q && at_top) ? 1'b0 : up_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign load_o = tick_i && at_top &&
                  ((fam_i == FAM_FAST) || (fam_i == FAM_PHASE && up_q));
  assign cnt_o  = cnt_q;
  assign up_o   = up_q;
endmodule

// File: rtl/tmr_cmp_buf.sv
module tmr_cmp_buf #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] raw_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                buf_q <= '0;
    else if (!pwm_i || load_i) buf_q <= raw_i;
  end

  assign act_o = pwm_i ? buf_q : raw_i;
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter bit IS_A  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  fam_e             fam_i,
  input  logic             wgm_hi_i,
  input  logic [1:0]       com_i,
  input  logic [CNT_W-1:0] ocr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             up_i,
  input  logic             dir_i,
  output logic             wave_o,
  output logic             ovr_o,
  output logic             oe_o
);
  logic wave_q, wave_d, tgl_ok, match;

  assign tgl_ok = is_pwm(fam_i) ? (IS_A && wgm_hi_i) : 1'b1;
  assign match  = cnt_i == ocr_i;

  always_comb begin
    wave_d = wave_q;
    if (com_i == 2'b01) begin
      if (tgl_ok && match) wave_d = ~wave_q;
    end else if (com_i[1]) begin
      // com_i[0]: level driven on an ordinary (or up-counting) match
      unique case (fam_i)
        FAM_NORMAL, FAM_CTC: if (match) wave_d = com_i[0];
        FAM_FAST: begin
          if (cnt_i >= top_i) wave_d = ~com_i[0];
          else if (match)     wave_d = com_i[0];
        end
        FAM_PHASE: begin
          if (ocr_i == top_i) begin
            if (cnt_i == top_i) wave_d = ~com_i[0];
          end else if (match) begin
            wave_d = up_i ? com_i[0] : ~com_i[0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (tick_i) wave_q <= wave_d;
  end

  assign wave_o = wave_q;
  assign ovr_o  = (com_i != 2'b00) && ((com_i != 2'b01) || tgl_ok);
  assign oe_o   = ovr_o && dir_i;
endmodule

// File: rtl/tmr_pwm_unit.sv
module tmr_pwm_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [2:0]       wgm_i,
  input  logic [1:0]       com_a_i,
  input  logic [1:0]       com_b_i,
  input  logic [CNT_W-1:0] ocr_a_i,
  input  logic [CNT_W-1:0] ocr_b_i,
  input  logic             dir_a_i,
  input  logic             dir_b_i,
  output logic             wave_a_o,
  output logic             wave_b_o,
  output logic             ovr_a_o,
  output logic             ovr_b_o,
  output logic             oe_a_o,
  output logic             oe_b_o
);
  localparam int N_CH = 2;

  wmode_t           wm;
  logic             pwm, up_q, load;
  logic [CNT_W-1:0] cnt_q, top_val, ocr_a_act;
  logic [CNT_W-1:0] raw [N_CH];
  logic [CNT_W-1:0] act [N_CH];
  logic [1:0]       com [N_CH];
  logic             dir [N_CH];
  logic             wave [N_CH];
  logic             ovr [N_CH];
  logic             oe [N_CH];

  assign wm        = decode_wgm(wgm_i);
  assign pwm       = is_pwm(wm.fam);
  assign raw[0]    = ocr_a_i;
  assign raw[1]    = ocr_b_i;
  assign com[0]    = com_a_i;
  assign com[1]    = com_b_i;
  assign dir[0]    = dir_a_i;
  assign dir[1]    = dir_b_i;
  assign ocr_a_act = act[0];
  assign top_val   = wm.top_ocr ? act[0] : {CNT_W{1'b1}};

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .fam_i  (wm.fam),
    .top_i  (top_val),
    .cnt_o  (cnt_q),
    .up_o   (up_q),
    .load_o (load)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pwm_i  (pwm),
      .load_i (load),
      .raw_i  (raw[g]),
      .act_o  (act[g])
    );

    tmr_wave_chan #(.CNT_W(CNT_W), .IS_A(g == 0)) u_wave (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .fam_i    (wm.fam),
      .wgm_hi_i (wgm_i[2]),
      .com_i    (com[g]),
      .ocr_i    (act[g]),
      .cnt_i    (cnt_q),
      .top_i    (top_val),
      .up_i     (up_q),
      .dir_i    (dir[g]),
      .wave_o   (wave[g]),
      .ovr_o    (ovr[g]),
      .oe_o     (oe[g])
    );
  end

  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];
  assign ovr_a_o  = ovr[0];
  assign ovr_b_o  = ovr[1];
  assign oe_a_o   = oe[0];
  assign oe_b_o   = oe[1];
endmodule

// File: rtl/tmr_pwm_unit_chk.sv
module tmr_pwm_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [2:0]       wgm_i,
  input logic [1:0]       com_a_i,
  input logic [1:0]       com_b_i,
  input logic             dir_a_i,
  input logic             dir_b_i,
  input logic             wave_a_o,
  input logic             wave_b_o,
  input logic             ovr_a_o,
  input logic             ovr_b_o,
  input logic             oe_a_o,
  input logic             oe_b_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] ocr_a_act_i
);
  AST_DISC_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_a_i == 2'b00 |-> !ovr_a_o && !oe_a_o); // R1
  AST_DISC_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_b_i == 2'b00 |-> !ovr_b_o && !oe_b_o); // R1
  AST_DIR_GATE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_a_i |-> !oe_a_o); // R2
  AST_DIR_GATE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_b_i |-> !oe_b_o); // R2
  AST_PWM_TGL_B_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wgm_i[0] && com_b_i == 2'b01 |-> !ovr_b_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(wave_a_o) && $stable(wave_b_o)); // R9
  AST_NORM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && wgm_i == 3'd0 |=> cnt_i == CNT_W'($past(cnt_i) + 1)); // R3
  AST_NONPWM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && wgm_i == 3'd0 && com_a_i == 2'b10 && cnt_i == ocr_a_act_i
    |=> !wave_a_o); // R3
  AST_FAST_TOP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && wgm_i == 3'd3 && com_b_i == 2'b10 && cnt_i == {CNT_W{1'b1}}
    |=> wave_b_o); // R4
endmodule

bind tmr_pwm_unit tmr_pwm_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wgm_i       (wgm_i),
  .com_a_i     (com_a_i),
  .com_b_i     (com_b_i),
  .dir_a_i     (dir_a_i),
  .dir_b_i     (dir_b_i),
  .wave_a_o    (wave_a_o),
  .wave_b_o    (wave_b_o),
  .ovr_a_o     (ovr_a_o),
  .ovr_b_o     (ovr_b_o),
  .oe_a_o      (oe_a_o),
  .oe_b_o      (oe_b_o),
  .cnt_i       (cnt_q),
  .ocr_a_act_i (ocr_a_act)
);

// File: tb/tmr_pwm_unit_tb_top.sv
module tmr_pwm_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] wgm_i = '0;
  logic [1:0] com_a_i = '0, com_b_i = '0;
  logic [7:0] ocr_a_i = '0, ocr_b_i = '0;
  logic       dir_a_i = 1'b0, dir_b_i = 1'b0;
  logic       wave_a_o, wave_b_o, ovr_a_o, ovr_b_o, oe_a_o, oe_b_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  // bench reference state
  int  m_cnt;
  bit  m_up;
  bit  m_w [2];
  int  m_buf [2];

  always #2 clk_i = ~clk_i;

  tmr_pwm_unit dut_i (
    .clk_i, .rst_ni, .tick_i, .wgm_i, .com_a_i, .com_b_i, .ocr_a_i, .ocr_b_i,
    .dir_a_i, .dir_b_i, .wave_a_o, .wave_b_o, .ovr_a_o, .ovr_b_o, .oe_a_o, .oe_b_o
  );

  // family per R11: 0 normal, 1 ctc, 2 fast, 3 phase
  function automatic int fam_of(input int w);
    case (w)
      1, 5:    return 3;
      2:       return 1;
      3, 7:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit top_from_a(input int w);
    return (w == 2) || (w == 5) || (w == 7);
  endfunction

  function automatic bit exp_ovr(input int ch, input int com, input int w);
    bit pwm = (fam_of(w) >= 2);
    if (com == 0) return 1'b0;
    if (com == 1 && pwm && !(ch == 0 && w >= 4)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit next_wave(input int ch, input int com, input int o,
                                   input bit w0, input int w, input int t,
                                   input int c, input bit up);
    int f = fam_of(w);
    bit tg = (f < 2) || (ch == 0 && w >= 4);
    if (com == 1) return (tg && c == o) ? !w0 : w0;
    if (com == 0) return w0;
    if (f < 2) return (c == o) ? (com == 3) : w0;
    if (f == 2) begin
      if (c >= t) return (com == 2);
      return (c == o) ? (com == 3) : w0;
    end
    if (o == t) return (c == t) ? (com == 2) : w0;
    if (c != o) return w0;
    return up ? (com == 3) : (com == 2);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1'b1; m_w[0] = 1'b0; m_w[1] = 1'b0;
    m_buf[0] = 0; m_buf[1] = 0;
  endtask

  // advance the reference over the coming clock edge
  task automatic model_step();
    int w = int'(wgm_i);
    int f = fam_of(w);
    bit pwm = (f >= 2);
    int raw [2];
    int act [2];
    int t, n;
    bit nu, ld;
    bit nw [2];
    raw[0] = int'(ocr_a_i); raw[1] = int'(ocr_b_i);
    for (int i = 0; i < 2; i++) act[i] = pwm ? m_buf[i] : raw[i];
    t = top_from_a(w) ? act[0] : 255;
    ld = 1'b0;
    if (tick_i) begin
      nw[0] = next_wave(0, int'(com_a_i), act[0], m_w[0], w, t, m_cnt, m_up);
      nw[1] = next_wave(1, int'(com_b_i), act[1], m_w[1], w, t, m_cnt, m_up);
      nu = 1'b1;
      case (f)
        1: n = (m_cnt == t) ? 0 : (m_cnt + 1) % 256;
        2: n = (m_cnt >= t) ? 0 : m_cnt + 1;
        3: begin
          if (m_up) n = (m_cnt >= t) ? ((m_cnt == 0) ? 0 : m_cnt - 1) : m_cnt + 1;
          else      n = (m_cnt == 0) ? 1 : m_cnt - 1;
          nu = (n == 0) ? 1'b1 : ((m_up && m_cnt >= t) ? 1'b0 : m_up);
        end
        default: n = (m_cnt + 1) % 256;
      endcase
      ld = (f == 2 && m_cnt >= t) || (f == 3 && m_up && m_cnt >= t);
      m_w[0] = nw[0]; m_w[1] = nw[1]; m_cnt = n; m_up = nu;
    end
    for (int i = 0; i < 2; i++) if (!pwm || ld) m_buf[i] = raw[i];
  endtask

  function automatic string tag_of(input int w, input int ca, input int cb,
                                   input int oa, input int ob);
    int f = fam_of(w);
    int t = top_from_a(w) ? oa : 255;
    if (w == 4 || w == 6) return "R11";
    if (f >= 2 && (ca == 1 || cb == 1)) return "R6";
    if (f >= 2 && (oa == t || ob == t)) return "R7";
    if (f == 2) return "R4";
    if (f == 3) return "R5";
    return "R3";
  endfunction

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_scn(input string req, input int w, input int ca, input int cb,
                         input int oa, input int ob, input bit da, input bit db,
                         input int div, input int chg_at, input int noa,
                         input int nob, input int cycles);
    bit bad = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    wgm_i = 3'(w); com_a_i = 2'(ca); com_b_i = 2'(cb);
    ocr_a_i = 8'(oa); ocr_b_i = 8'(ob); dir_a_i = da; dir_b_i = db; tick_i = 1'b0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      if (c == chg_at) begin ocr_a_i = 8'(noa); ocr_b_i = 8'(nob); end
      tick_i = ((c % div) == 0);
      model_step();
      @(negedge clk_i);
      if (!bad && (wave_a_o !== m_w[0] || wave_b_o !== m_w[1] ||
                   ovr_a_o !== exp_ovr(0, ca, w) || ovr_b_o !== exp_ovr(1, cb, w) ||
                   oe_a_o !== (exp_ovr(0, ca, w) && da) ||
                   oe_b_o !== (exp_ovr(1, cb, w) && db))) begin
        bad = 1'b1;
        $display("FAIL %s wgm=%0d com=%0d/%0d ocr=%0d/%0d cyc=%0d: actual wave=%b%b ovr=%b%b oe=%b%b expected wave=%b%b ovr=%b%b oe=%b%b",
                 req, w, ca, cb, oa, ob, c, wave_a_o, wave_b_o, ovr_a_o, ovr_b_o,
                 oe_a_o, oe_b_o, m_w[0], m_w[1], exp_ovr(0, ca, w), exp_ovr(1, cb, w),
                 exp_ovr(0, ca, w) && da, exp_ovr(1, cb, w) && db);
      end
    end
    n_tests++;
    if (bad) n_fail++;
  endtask

  initial begin
    int pa [4];
    int pb [4];
    pa = '{40, 255, 0, 100};
    pb = '{17, 255, 40, 100};

    // R10: reset state
    #1;
    check_bit("R10", "wave_a in reset", wave_a_o, 1'b0);
    check_bit("R10", "wave_b in reset", wave_b_o, 1'b0);

    // R1 / R2: disconnect and direction gating at the ports
    rst_ni = 1'b1; wgm_i = 3'd0; com_a_i = 2'b00; dir_a_i = 1'b1;
    com_b_i = 2'b11; dir_b_i = 1'b0;
    @(negedge clk_i);
    check_bit("R1", "ovr_a with action 00", ovr_a_o, 1'b0);
    check_bit("R1", "oe_a with action 00", oe_a_o, 1'b0);
    check_bit("R2", "ovr_b with dir 0", ovr_b_o, 1'b1);
    check_bit("R2", "oe_b with dir 0", oe_b_o, 1'b0);
    dir_b_i = 1'b1;
    @(negedge clk_i);
    check_bit("R2", "oe_b with dir 1", oe_b_o, 1'b1);

    // main sweep: every mode, every action on both channels, four compare pairs
    for (int w = 0; w < 8; w++)
      for (int ca = 0; ca < 4; ca++)
        for (int p = 0; p < 4; p++)
          run_scn(tag_of(w, ca, (ca + 1) % 4, pa[p], pb[p]), w, ca, (ca + 1) % 4,
                  pa[p], pb[p], p[0], !p[0], 1, -1, 0, 0, 600);

    // R9: sparse tick
    for (int w = 0; w < 8; w++)
      run_scn("R9", w, 2, 3, 40, 17, 1'b1, 1'b1, 3, -1, 0, 0, 600);

    // R8: compare change mid-period
    for (int w = 0; w < 8; w++)
      run_scn("R8", w, 3, 2, 40, 17, 1'b1, 1'b1, 1, 150, 20, 30, 900);

    // R10: asynchronous reset while an output is high
    run_scn("R4", 3, 3, 0, 10, 0, 1'b1, 1'b0, 1, -1, 0, 0, 50);
    check_bit("R4", "wave_a set after match", wave_a_o, 1'b1);
    #1 rst_ni = 1'b0;
    #1;
    check_bit("R10", "wave_a after async reset", wave_a_o, 1'b0);
    check_bit("R10", "wave_b after async reset", wave_b_o, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule